// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Front End

This block sits between an 8-bit parallel host bus and the core of a display controller. The host can signal in either of two styles. In the first, one pin gives the direction and a separate pin is a high-true enable. In the second, the two pins are separate low-true write and read strobes. A static 3-bit mode code picks the style. The two parallel codes switch the block on. The serial and two-wire codes leave it silent, because those ports are handled elsewhere.

Host strobes, chip select, the data/command line and the data byte are asynchronous to the core clock. They pass through a two-flop synchroniser before edges are detected. Each host write becomes one single-cycle `wr_valid` pulse that carries the byte and a data/command tag. Each host read raises a single-cycle `rd_req` pulse at the start of the strobe, so that the core can advance its read pointer.

During a read cycle the block drives the core's `rd_data` onto the bus. Drive follows the raw pins without delay. The bidirectional bus appears as separate `bus_in`, `bus_out` and `bus_oe` pins, for a pad cell to join. The bus is released whenever the chip is deselected, the mode is not parallel, or reset is held.

Top module: `hostbus_par_if`

## Requirements
- R1: `par_active` is 1 exactly when `mode_sel` is 3'b010 (enable-style) or 3'b011 (strobe-style), and is 0 for every other code.
- R2: While `cs_n` is high, host strobes produce no `wr_valid` and no `rd_req` pulse.
- R3: While `cs_n` is high, `bus_oe` is 0.
- R4: `wr_is_data` and `rd_is_data` carry the level of `dc` for the transfer: 1 means display data, 0 means a command byte.
- R5: In enable-style mode, a falling edge on `e_rd_n` (enable) while `rw_wr_n` is low and `cs_n` is low produces one `wr_valid` pulse carrying `bus_in`.
- R6: In enable-style mode, `bus_oe` is 1 and `bus_out` equals `rd_data` while `e_rd_n` is high, `rw_wr_n` is high and `cs_n` is low. The rising edge of enable under these conditions produces one `rd_req` pulse.
- R7: In strobe-style mode, a rising edge on `rw_wr_n` (write strobe, low-true) while `cs_n` is low produces one `wr_valid` pulse carrying `bus_in`.
- R8: In strobe-style mode, `bus_oe` is 1 and `bus_out` equals `rd_data` while `e_rd_n` (read strobe, low-true) is low and `cs_n` is low. The falling edge of the read strobe produces one `rd_req` pulse.
- R9: Each accepted access produces exactly one pulse, which is one cycle wide and appears within 4 clocks of the strobe edge.
- R10: In a non-parallel mode, `bus_oe`, `wr_valid` and `rd_req` stay 0 whatever the pins do.
- R11: While `rst_n` is low, `bus_oe`, `wr_valid` and `rd_req` are 0. After release the block is idle and issues no spurious pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, low-true |
| mode_sel | input | 3 | Static bus mode code |
| cs_n | input | 1 | Chip select, low-true |
| dc | input | 1 | Data (1) / command (0) tag |
| rw_wr_n | input | 1 | Direction (enable-style) or write strobe (strobe-style) |
| e_rd_n | input | 1 | Enable (enable-style) or read strobe (strobe-style) |
| bus_in | input | 8 | Bus value from pad |
| bus_out | output | 8 | Bus value to pad |
| bus_oe | output | 1 | Pad output enable |
| rd_data | input | 8 | Read byte supplied by the core |
| par_active | output | 1 | Parallel mode selected |
| wr_valid | output | 1 | Write pulse |
| wr_byte | output | 8 | Written byte |
| wr_is_data | output | 1 | Tag of written byte |
| rd_req | output | 1 | Read-start pulse |
| rd_is_data | output | 1 | Tag of read access |

## Verification
Writes and reads are run in both parallel styles, with data and command tags alternating and several byte values. This separates the capture edge, the tag and the byte path in each style. The same strobes are then repeated with chip select high and in a serial mode code. There any pulse or bus drive counts as a miscompare, which separates the select gating from the mode gating. A reset held in the middle of a read cycle shows whether the bus is released while reset is asserted.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [2:0] {
    BM_SER3 = 3'b000,
    BM_SER4 = 3'b001,
    BM_ENSTY = 3'b010,
    BM_STBSTY = 3'b011,
    BM_TWOW = 3'b100
  } bus_mode_e;

  function automatic logic mode_is_en(input logic [2:0] m);
    return m == BM_ENSTY;
  endfunction

  function automatic logic mode_is_stb(input logic [2:0] m);
    return m == BM_STBSTY;
  endfunction

  function automatic logic mode_is_par(input logic [2:0] m);
    return mode_is_en(m) || mode_is_stb(m);
  endfunction

  function automatic logic rise(input logic prev, input logic cur);
    return !prev && cur;
  endfunction

  function automatic logic fall(input logic prev, input logic cur);
    return prev && !cur;
  endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int W = 12,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbp_evt.sv
module hbp_evt
  import hbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]  mode_sel,
  input  logic        cs_c, dc_c, rw_c, st_c,
  input  logic        cs_p, dc_p, rw_p, st_p,
  input  logic [DW-1:0] d_p,
  output logic        wr_evt,
  output logic        rd_evt,
  output logic [DW-1:0] evt_byte,
  output logic        wr_tag,
  output logic        rd_tag
);
  logic en_mode, stb_mode;
  assign en_mode  = mode_is_en(mode_sel);
  assign stb_mode = mode_is_stb(mode_sel);

  always_comb begin
    wr_evt = 1'b0;
    rd_evt = 1'b0;
    if (en_mode) begin
      wr_evt = fall(st_p, st_c) && !rw_p && !cs_p;
      rd_evt = rise(st_p, st_c) && rw_c && !cs_c;
    end else if (stb_mode) begin
      wr_evt = rise(rw_p, rw_c) && !cs_p;
      rd_evt = fall(st_p, st_c) && !cs_c;
    end
  end

  assign evt_byte = d_p;
  assign wr_tag   = dc_p;
  assign rd_tag   = dc_c;
endmodule

// File: rtl/hbp_drive.sv
module hbp_drive
  import hbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          cs_n,
  input  logic          rw_wr_n,
  input  logic          e_rd_n,
  input  logic [DW-1:0] rd_data,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out
);
  logic rd_phase;
  always_comb begin
    rd_phase = 1'b0;
    if (mode_is_en(mode_sel))       rd_phase = e_rd_n && rw_wr_n;
    else if (mode_is_stb(mode_sel)) rd_phase = !e_rd_n;
  end

  assign bus_oe  = rst_n && !cs_n && rd_phase;
  assign bus_out = bus_oe ? rd_data : '0;
endmodule

// File: rtl/hostbus_par_if.sv
module hostbus_par_if
  import hbp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          cs_n,
  input  logic          dc,
  input  logic          rw_wr_n,
  input  logic          e_rd_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] rd_data,
  output logic          par_active,
  output logic          wr_valid,
  output logic [DW-1:0] wr_byte,
  output logic          wr_is_data,
  output logic          rd_req,
  output logic          rd_is_data
);
  localparam int PW   = DW + 4;
  localparam int CS_B = DW + 3;
  localparam int DC_B = DW + 2;
  localparam int RW_B = DW + 1;
  localparam int ST_B = DW;
  localparam logic [PW-1:0] IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [PW-1:0] pins_raw, pins_s, pins_p;
  assign pins_raw = {cs_n, dc, rw_wr_n, e_rd_n, bus_in};

  hbp_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_p <= IDLE;
    else        pins_p <= pins_s;
  end

  // named internal events, visible to assertions
  logic wr_evt, rd_evt, wr_tag, rd_tag;
  logic [DW-1:0] evt_byte;

  hbp_evt #(.DW(DW)) u_evt (
    .mode_sel(mode_sel),
    .cs_c(pins_s[CS_B]), .dc_c(pins_s[DC_B]), .rw_c(pins_s[RW_B]), .st_c(pins_s[ST_B]),
    .cs_p(pins_p[CS_B]), .dc_p(pins_p[DC_B]), .rw_p(pins_p[RW_B]), .st_p(pins_p[ST_B]),
    .d_p(pins_p[DW-1:0]),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .evt_byte(evt_byte),
    .wr_tag(wr_tag), .rd_tag(rd_tag)
  );

  hbp_drive #(.DW(DW)) u_drive (
    .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rw_wr_n(rw_wr_n),
    .e_rd_n(e_rd_n), .rd_data(rd_data), .bus_oe(bus_oe), .bus_out(bus_out)
  );

  assign par_active = mode_is_par(mode_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_byte    <= '0;
      wr_is_data <= 1'b0;
      rd_req     <= 1'b0;
      rd_is_data <= 1'b0;
    end else begin
      wr_valid <= wr_evt;
      rd_req   <= rd_evt;
      if (wr_evt) begin
        wr_byte    <= evt_byte;
        wr_is_data <= wr_tag;
      end
      if (rd_evt) rd_is_data <= rd_tag;
    end
  end

  // assertions
  p_deselect_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !bus_oe);
  p_wr_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  p_rd_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_nonpar_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !par_active |-> (!wr_valid && !rd_req && !bus_oe));
  p_evt_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_evt, rd_evt}) <= 1);
  always_comb begin
    if (!rst_n) p_reset_release_r11: assert (!bus_oe);
  end
endmodule

// File: tb/hostbus_par_if_test.sv
`timescale 1ns/1ps
module hostbus_par_if_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0;
  logic [2:0] mode_sel = 3'b010;
  logic cs_n = 1, dc = 0, rw_wr_n = 1, e_rd_n = 0;
  logic [7:0] bus_in = 0, rd_data = 0;
  logic [7:0] bus_out, wr_byte;
  logic bus_oe, par_active, wr_valid, wr_is_data, rd_req, rd_is_data;

  hostbus_par_if uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .dc(dc),
    .rw_wr_n(rw_wr_n), .e_rd_n(e_rd_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rd_data(rd_data), .par_active(par_active),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_is_data(wr_is_data),
    .rd_req(rd_req), .rd_is_data(rd_is_data)
  );

  typedef struct {
    bit is_rd;
    bit tag;
    logic [7:0] b;
    string req;
  } exp_t;
  exp_t sb[$];

  int vec = 0, miss = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (wr_valid || rd_req)) begin
      if (sb.size() == 0) begin
        chk(0, "R2/R10 unexpected pulse", {wr_valid, rd_req}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_rd) begin
          chk(rd_req && !wr_valid, {e.req, " read pulse"}, {wr_valid, rd_req}, 2'b01);
          chk(rd_is_data == e.tag, {e.req, " R4 read tag"}, rd_is_data, e.tag);
        end else begin
          chk(wr_valid && !rd_req, {e.req, " write pulse"}, {wr_valid, rd_req}, 2'b10);
          chk(wr_byte == e.b, {e.req, " byte"}, wr_byte, e.b);
          chk(wr_is_data == e.tag, {e.req, " R4 write tag"}, wr_is_data, e.tag);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 0;
    mode_sel = m;
    cs_n = 1; rw_wr_n = 1;
    e_rd_n = (m == 3'b011) ? 1'b1 : 1'b0;
    idle(3);
    rst_n = 1;
    idle(4);
  endtask

  // enable-style write (R5)
  task automatic en_write(input bit t, input logic [7:0] b, input bit push);
    cs_n = push ? 1'b0 : cs_n; dc = t; rw_wr_n = 0; bus_in = b;
    idle(3);
    e_rd_n = 1; idle(4);
    e_rd_n = 0;
    if (push) sb.push_back('{0, t, b, "R5"});
    idle(4);
    cs_n = 1; rw_wr_n = 1; idle(6);
  endtask

  // enable-style read (R6)
  task automatic en_read(input bit t, input logic [7:0] rdv, input bit push);
    rd_data = rdv; cs_n = push ? 1'b0 : cs_n; dc = t; rw_wr_n = 1;
    idle(3);
    e_rd_n = 1;
    if (push) sb.push_back('{1, t, 8'h00, "R6"});
    #1;
    if (push) begin
      chk(bus_oe == 1, "R6 bus_oe", bus_oe, 1);
      chk(bus_out == rdv, "R6 bus_out", bus_out, rdv);
    end else chk(bus_oe == 0, "R3/R10 bus_oe", bus_oe, 0);
    idle(4);
    e_rd_n = 0; #1;
    chk(bus_oe == 0, "R6 release", bus_oe, 0);
    idle(4);
    cs_n = 1; idle(6);
  endtask

  // strobe-style write (R7)
  task automatic stb_write(input bit t, input logic [7:0] b, input bit push);
    cs_n = push ? 1'b0 : cs_n; dc = t; bus_in = b;
    idle(3);
    rw_wr_n = 0; idle(4);
    rw_wr_n = 1;
    if (push) sb.push_back('{0, t, b, "R7"});
    idle(4);
    cs_n = 1; idle(6);
  endtask

  // strobe-style read (R8)
  task automatic stb_read(input bit t, input logic [7:0] rdv, input bit push);
    rd_data = rdv; cs_n = push ? 1'b0 : cs_n; dc = t;
    idle(3);
    e_rd_n = 0;
    if (push) sb.push_back('{1, t, 8'h00, "R8"});
    #1;
    if (push) begin
      chk(bus_oe == 1, "R8 bus_oe", bus_oe, 1);
      chk(bus_out == rdv, "R8 bus_out", bus_out, rdv);
    end else chk(bus_oe == 0, "R3/R10 bus_oe", bus_oe, 0);
    idle(4);
    e_rd_n = 1; #1;
    chk(bus_oe == 0, "R8 release", bus_oe, 0);
    idle(4);
    cs_n = 1; idle(6);
  endtask

  task automatic drain(input string req);
    idle(6);
    chk(sb.size() == 0, {req, " R9 missing pulse"}, sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    // reset state (R11)
    idle(2);
    chk(bus_oe == 0 && wr_valid == 0 && rd_req == 0, "R11 reset outputs",
        {bus_oe, wr_valid, rd_req}, 0);
    // mode decode (R1)
    for (int m = 0; m < 8; m++) begin
      mode_sel = m[2:0]; #1;
      chk(par_active == (m == 2 || m == 3), "R1 mode decode", par_active, (m == 2 || m == 3));
    end

    do_reset(3'b010);
    chk(wr_valid == 0 && rd_req == 0, "R11 idle after release", {wr_valid, rd_req}, 0);
    en_write(1, 8'hA5, 1);
    en_write(0, 8'h3C, 1);
    en_write(1, 8'hFF, 1);
    en_read(1, 8'h5A, 1);
    en_read(0, 8'h81, 1);
    drain("R5/R6");
    // deselected (R2, R3)
    en_write(1, 8'h77, 0);
    en_read(1, 8'h11, 0);
    drain("R2");

    do_reset(3'b011);
    stb_write(0, 8'h01, 1);
    stb_write(1, 8'hC3, 1);
    stb_read(1, 8'h9E, 1);
    stb_read(0, 8'h42, 1);
    drain("R7/R8");
    stb_write(1, 8'h66, 0);
    stb_read(0, 8'h24, 0);
    drain("R2");

    // non-parallel mode (R10): chip selected, strobes toggled
    do_reset(3'b000);
    cs_n = 0; rw_wr_n = 0; e_rd_n = 0; idle(4);
    rw_wr_n = 1; e_rd_n = 1; #1;
    chk(bus_oe == 0, "R10 bus_oe", bus_oe, 0);
    idle(4); e_rd_n = 0; #1;
    chk(bus_oe == 0, "R10 bus_oe", bus_oe, 0);
    idle(6); cs_n = 1;
    drain("R10");

    // reset during an active read (R11)
    do_reset(3'b010);
    cs_n = 0; rw_wr_n = 1; rd_data = 8'hEE; idle(3);
    e_rd_n = 1; #1;
    chk(bus_oe == 1, "R6 bus_oe pre-reset", bus_oe, 1);
    rst_n = 0; #1;
    chk(bus_oe == 0, "R11 bus released in reset", bus_oe, 0);
    idle(3);
    chk(wr_valid == 0 && rd_req == 0, "R11 no pulse in reset", {wr_valid, rd_req}, 0);
    e_rd_n = 0; cs_n = 1; idle(2);
    rst_n = 1; idle(8);
    drain("R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vec++; miss++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end
endmodule